// File: doc/BRIEF.md
# Register-to-Register ALU with Status Flags

This block executes the two-register arithmetic and logic group of an 8-bit microcontroller core. It decodes a 16-bit instruction word and reads two operands out of a bank of 32 eight-bit registers through 32-way selectors. It performs add, add-with-carry, subtract, subtract-with-carry, compare, compare-with-carry, AND, OR or exclusive-OR on them. Except for the two compares, it writes the result back into the register that supplied the first operand. Each recognised instruction also updates a six-flag status word.

An instruction is presented with a one-cycle valid strobe. It completes at that clock edge, so a new instruction can be issued every cycle. A separate write port loads registers from outside, and a combinational read port observes them. These are the register-file ports through which the surrounding core moves data in and out.

Top module: `regalu_exec`

## Requirements
- R1: Synchronous active-high reset clears all 32 registers and the status word. The status bit positions are C=0, Z=1, N=2, V=3, S=4 and H=5.
- R2: Bits 15:10 of the word select the operation. The codes are add 000011, add-with-carry 000111, subtract 000110, subtract-with-carry 000010, compare 000101, compare-with-carry 000001, AND 001000, OR 001010 and exclusive-OR 001001. The first operand and destination index is {bit 8, bits 7:4}. The second operand index is {bit 9, bits 3:0}. The two indexes may be equal.
- R3: Add and add-with-carry store the 8-bit sum, plus C when carry-in is used, in the destination at the edge where valid is sampled. C is set when the true sum exceeds 0xFF. Z is set when the 8-bit result is zero, including a sum of exactly 256.
- R4: Subtract and subtract-with-carry store first minus second (minus C when carry-in is used). C is set when a borrow occurs, which means the subtrahend plus carry-in exceeds the first operand.
- R5: Every arithmetic operation updates N, V, S and H. N is result bit 7. V is two's-complement overflow. S is N XOR V. H is the carry out of bit 3 for additions, and the borrow into bit 3 from bit 4 for subtractions.
- R6: Add-with-carry of a register with itself rotates it left through carry. Old bit 7 goes to C and old C enters bit 0.
- R7: Compare and compare-with-carry set the flags exactly as the matching subtractions would. They leave every register unchanged.
- R8: For subtract-with-carry and compare-with-carry, Z is cleared when the result is nonzero. When the result is zero, Z keeps its previous value.
- R9: AND, OR and exclusive-OR store the bitwise result. They clear V, set N to result bit 7, set S equal to N and set Z for a zero result. They leave C and H unchanged.
- R10: Exclusive-OR of a register with itself clears the register and sets Z. AND of a register with itself leaves it unchanged and sets Z only when the register is zero.
- R11: A valid word whose bits 15:10 match none of the listed codes changes no register and no flag.
- R12: The external write port stores data at the clock edge. If it targets the same register as an instruction write-back in the same cycle, the write-back wins. Writes to different registers both take effect.
- R13: While valid is low, the flags and registers hold, whatever the instruction word carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 16 | Instruction word |
| ext_we | input | 1 | External register write enable |
| ext_waddr | input | 5 | External write register index |
| ext_wdata | input | 8 | External write data |
| ext_raddr | input | 5 | External read register index |
| ext_rdata | output | 8 | Register contents at ext_raddr (combinational) |
| status | output | 6 | Status flags {H,S,V,N,Z,C} |

## Verification
Each result is due one register stage after its stimulus. The destination register and the status word take their new values at the same rising edge where insn_valid is sampled high. An external write likewise lands at the edge where ext_we is sampled. The bench therefore drives on the falling edge and lets one rising edge pass. On the following falling edge it sets the read index and samples the combinational read port and the status output. A reference model computed with integer arithmetic sweeps every operation over a grid of operand values and four preset flag states. Directed cases cover self-operand, collision, idle and unknown-code behaviour.

// File: rtl/regalu_pkg.sv
`timescale 1ns/1ps
package regalu_pkg;

    localparam int WORD_W    = 16;
    localparam int OPC_W     = 6;
    localparam int REG_IDX_W = 5;
    localparam int NUM_REGS  = 1 << REG_IDX_W;
    localparam int FLAG_W    = 6;

    // Operation codes taken from word bits 15:10
    localparam logic [OPC_W-1:0] OPC_ADD = 6'b000011;
    localparam logic [OPC_W-1:0] OPC_ADC = 6'b000111;
    localparam logic [OPC_W-1:0] OPC_SUB = 6'b000110;
    localparam logic [OPC_W-1:0] OPC_SBC = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_CP  = 6'b000101;
    localparam logic [OPC_W-1:0] OPC_CPC = 6'b000001;
    localparam logic [OPC_W-1:0] OPC_AND = 6'b001000;
    localparam logic [OPC_W-1:0] OPC_OR  = 6'b001010;
    localparam logic [OPC_W-1:0] OPC_EOR = 6'b001001;

    typedef enum logic [1:0] {
        UNIT_ADD   = 2'd0,
        UNIT_SUB   = 2'd1,
        UNIT_LOGIC = 2'd2
    } unit_e;

    typedef enum logic [1:0] {
        LFN_AND = 2'd0,
        LFN_OR  = 2'd1,
        LFN_XOR = 2'd2
    } logic_fn_e;

    typedef struct packed {
        logic      legal;
        unit_e     unit;
        logic_fn_e lfn;
        logic      use_carry;
        logic      keep_z;
        logic      writeback;
    } alu_ctl_t;

    // Packed so that c lands on bit 0 and h on bit 5
    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_t;

    function automatic alu_ctl_t decode_opc(input logic [OPC_W-1:0] opc);
        alu_ctl_t ctl;
        ctl           = '0;
        ctl.unit      = UNIT_ADD;
        ctl.lfn       = LFN_AND;
        ctl.legal     = 1'b1;
        ctl.writeback = 1'b1;
        case (opc)
            OPC_ADD: ctl.unit = UNIT_ADD;
            OPC_ADC: begin ctl.unit = UNIT_ADD; ctl.use_carry = 1'b1; end
            OPC_SUB: ctl.unit = UNIT_SUB;
            OPC_SBC: begin
                ctl.unit = UNIT_SUB; ctl.use_carry = 1'b1; ctl.keep_z = 1'b1;
            end
            OPC_CP:  begin ctl.unit = UNIT_SUB; ctl.writeback = 1'b0; end
            OPC_CPC: begin
                ctl.unit = UNIT_SUB; ctl.use_carry = 1'b1; ctl.keep_z = 1'b1;
                ctl.writeback = 1'b0;
            end
            OPC_AND: begin ctl.unit = UNIT_LOGIC; ctl.lfn = LFN_AND; end
            OPC_OR:  begin ctl.unit = UNIT_LOGIC; ctl.lfn = LFN_OR;  end
            OPC_EOR: begin ctl.unit = UNIT_LOGIC; ctl.lfn = LFN_XOR; end
            default: begin ctl.legal = 1'b0; ctl.writeback = 1'b0; end
        endcase
        return ctl;
    endfunction

    function automatic logic [REG_IDX_W-1:0] dst_field(input logic [WORD_W-1:0] w);
        return {w[8], w[7:4]};
    endfunction

    function automatic logic [REG_IDX_W-1:0] src_field(input logic [WORD_W-1:0] w);
        return {w[9], w[3:0]};
    endfunction

endpackage

// File: rtl/regalu_decode.sv
`timescale 1ns/1ps
module regalu_decode
    import regalu_pkg::*;
(
    input  logic [WORD_W-1:0]    word,
    output alu_ctl_t             ctl,
    output logic [REG_IDX_W-1:0] dst_idx,
    output logic [REG_IDX_W-1:0] src_idx
);
    always_comb begin
        ctl     = decode_opc(word[WORD_W-1 -: OPC_W]);
        dst_idx = dst_field(word);
        src_idx = src_field(word);
    end
endmodule

// File: rtl/regalu_regbank.sv
`timescale 1ns/1ps
module regalu_regbank
    import regalu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREGS  = NUM_REGS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(NREGS)-1:0]     rd_a_idx,
    input  logic [$clog2(NREGS)-1:0]     rd_b_idx,
    input  logic [$clog2(NREGS)-1:0]     rd_x_idx,
    output logic [DATA_W-1:0]            rd_a,
    output logic [DATA_W-1:0]            rd_b,
    output logic [DATA_W-1:0]            rd_x,
    input  logic                         wb_en,
    input  logic [$clog2(NREGS)-1:0]     wb_idx,
    input  logic [DATA_W-1:0]            wb_data,
    input  logic                         xw_en,
    input  logic [$clog2(NREGS)-1:0]     xw_idx,
    input  logic [DATA_W-1:0]            xw_data
);
    localparam int IDX_W = $clog2(NREGS);

    logic [DATA_W-1:0] regs [NREGS];

    // One register per entry; write-back has priority over the external port
    for (genvar i = 0; i < NREGS; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (wb_en && wb_idx == IDX_W'(i)) begin
                regs[i] <= wb_data;
            end else if (xw_en && xw_idx == IDX_W'(i)) begin
                regs[i] <= xw_data;
            end
        end
    end

    // Three independent 32-way selectors
    always_comb begin
        rd_a = regs[rd_a_idx];
        rd_b = regs[rd_b_idx];
        rd_x = regs[rd_x_idx];
    end
endmodule

// File: rtl/regalu_core.sv
`timescale 1ns/1ps
module regalu_core
    import regalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_ctl_t          ctl,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  sreg_t             flags_in,
    output logic [DATA_W-1:0] result,
    output sreg_t             flags_out
);
    localparam int MSB    = DATA_W - 1;
    localparam int HALF_W = 4;

    logic              cin;
    logic [DATA_W:0]   add_full;
    logic [DATA_W:0]   sub_full;
    logic [HALF_W:0]   add_low;
    logic [HALF_W:0]   sub_low;
    logic [DATA_W-1:0] logic_res;
    logic              zero_res;

    always_comb begin
        cin      = ctl.use_carry & flags_in.c;
        add_full = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, cin};
        sub_full = {1'b0, op_a} - {1'b0, op_b} - {{DATA_W{1'b0}}, cin};
        add_low  = {1'b0, op_a[HALF_W-1:0]} + {1'b0, op_b[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, cin};
        sub_low  = {1'b0, op_a[HALF_W-1:0]} - {1'b0, op_b[HALF_W-1:0]}
                 - {{HALF_W{1'b0}}, cin};

        case (ctl.lfn)
            LFN_OR:  logic_res = op_a | op_b;
            LFN_XOR: logic_res = op_a ^ op_b;
            default: logic_res = op_a & op_b;
        endcase

        flags_out = flags_in;
        case (ctl.unit)
            UNIT_ADD: begin
                result      = add_full[DATA_W-1:0];
                flags_out.c = add_full[DATA_W];
                flags_out.h = add_low[HALF_W];
                flags_out.v = (op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB]);
            end
            UNIT_SUB: begin
                result      = sub_full[DATA_W-1:0];
                flags_out.c = sub_full[DATA_W];
                flags_out.h = sub_low[HALF_W];
                flags_out.v = (op_a[MSB] != op_b[MSB]) && (result[MSB] != op_a[MSB]);
            end
            default: begin
                result      = logic_res;
                flags_out.v = 1'b0;
            end
        endcase

        zero_res    = (result == '0);
        flags_out.n = result[MSB];
        flags_out.s = flags_out.n ^ flags_out.v;
        flags_out.z = ctl.keep_z ? (zero_res & flags_in.z) : zero_res;
    end
endmodule

// File: rtl/regalu_exec.sv
`timescale 1ns/1ps
module regalu_exec
    import regalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  insn_valid,
    input  logic [15:0]           insn_word,
    input  logic                  ext_we,
    input  logic [4:0]            ext_waddr,
    input  logic [DATA_W-1:0]     ext_wdata,
    input  logic [4:0]            ext_raddr,
    output logic [DATA_W-1:0]     ext_rdata,
    output logic [5:0]            status
);
    alu_ctl_t             ctl;
    logic [REG_IDX_W-1:0] dst_idx;
    logic [REG_IDX_W-1:0] src_idx;
    logic [DATA_W-1:0]    op_a;
    logic [DATA_W-1:0]    op_b;
    logic [DATA_W-1:0]    alu_res;
    sreg_t                flags_q;
    sreg_t                flags_nx;
    logic                 exec_en;
    logic                 wb_en;

    regalu_decode u_decode (
        .word    (insn_word),
        .ctl     (ctl),
        .dst_idx (dst_idx),
        .src_idx (src_idx)
    );

    assign exec_en = insn_valid && ctl.legal;
    assign wb_en   = exec_en && ctl.writeback;

    regalu_regbank #(.DATA_W(DATA_W), .NREGS(NUM_REGS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (dst_idx),
        .rd_b_idx (src_idx),
        .rd_x_idx (ext_raddr),
        .rd_a     (op_a),
        .rd_b     (op_b),
        .rd_x     (ext_rdata),
        .wb_en    (wb_en),
        .wb_idx   (dst_idx),
        .wb_data  (alu_res),
        .xw_en    (ext_we),
        .xw_idx   (ext_waddr),
        .xw_data  (ext_wdata)
    );

    regalu_core #(.DATA_W(DATA_W)) u_core (
        .ctl       (ctl),
        .op_a      (op_a),
        .op_b      (op_b),
        .flags_in  (flags_q),
        .result    (alu_res),
        .flags_out (flags_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (exec_en) begin
            flags_q <= flags_nx;
        end
    end

    assign status = flags_q;
endmodule

// File: rtl/regalu_checker.sv
`timescale 1ns/1ps
module regalu_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              insn_valid,
    input logic [15:0]       insn_word,
    input logic [5:0]        status,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b
);
    logic [5:0] opc;
    logic       is_logic_op;
    logic       is_chain_sub;
    logic       is_known;

    always_comb begin
        opc          = insn_word[15:10];
        is_logic_op  = (opc == 6'b001000) || (opc == 6'b001010) || (opc == 6'b001001);
        is_chain_sub = (opc == 6'b000010) || (opc == 6'b000001);
        is_known     = is_logic_op || is_chain_sub || (opc == 6'b000011) ||
                       (opc == 6'b000111) || (opc == 6'b000110) || (opc == 6'b000101);
    end

    // R13: flags hold while no instruction is issued
    assert_idle_hold_R13: assert property (@(posedge clk) disable iff (rst)
        !insn_valid |=> $stable(status));

    // R11: unknown operation codes leave the flags alone
    assert_unknown_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && !is_known) |=> $stable(status));

    // R9: logic operations clear V and keep C and H
    assert_logic_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && is_logic_op) |=>
            (!status[3] && status[0] == $past(status[0]) && status[5] == $past(status[5])));

    // R8: chained subtract/compare never raises Z
    assert_chain_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && is_chain_sub && !status[1]) |=> !status[1]);

    // R3: add carry equals the true sum exceeding the data range
    assert_add_carry_R3: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && opc == 6'b000011) |=>
            (status[0] == $past(({1'b0, op_a} + {1'b0, op_b}) > {1'b0, {DATA_W{1'b1}}})));
endmodule

bind regalu_exec regalu_checker #(.DATA_W(DATA_W)) u_regalu_checker (
    .clk        (clk),
    .rst        (rst),
    .insn_valid (insn_valid),
    .insn_word  (insn_word),
    .status     (status),
    .op_a       (op_a),
    .op_b       (op_b)
);

// File: tb/test_regalu_exec.sv
`timescale 1ns/1ps
module test_regalu_exec;

    localparam logic [5:0] C_ADD = 6'b000011, C_ADC = 6'b000111, C_SUB = 6'b000110,
                           C_SBC = 6'b000010, C_CP  = 6'b000101, C_CPC = 6'b000001,
                           C_AND = 6'b001000, C_OR  = 6'b001010, C_EOR = 6'b001001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_valid = 1'b0;
    logic [15:0] insn_word = '0;
    logic        ext_we = 1'b0;
    logic [4:0]  ext_waddr = '0;
    logic [7:0]  ext_wdata = '0;
    logic [4:0]  ext_raddr = '0;
    logic [7:0]  ext_rdata;
    logic [5:0]  status;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [7:0] mreg [32];
    logic [5:0] mflags;

    always #2.5 clk = ~clk;

    regalu_exec i_regalu_exec (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
        .ext_we(ext_we), .ext_waddr(ext_waddr), .ext_wdata(ext_wdata),
        .ext_raddr(ext_raddr), .ext_rdata(ext_rdata), .status(status)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] sweep_val(input int k);
        case (k)
            0: return 8'h00;  1: return 8'h01;  2: return 8'h0F;  3: return 8'h10;
            4: return 8'h7F;  5: return 8'h80;  6: return 8'h81;  7: return 8'hFE;
            8: return 8'hFF;  9: return 8'h3C; 10: return 8'hA5; default: return 8'h5A;
        endcase
    endfunction

    // Reference computed with integer arithmetic from the requirements
    function automatic void model_exec(input logic [5:0] op, input logic [7:0] a,
                                       input logic [7:0] b, input logic [5:0] fi,
                                       output logic [7:0] r, output logic [5:0] fo,
                                       output bit wr, output bit legal);
        int ci, ia, ib, sa, sb, t, sv;
        bit c, z, n, v, h;
        legal = 1; wr = 1;
        c = fi[0]; h = fi[5]; v = 0; r = '0;
        ia = int'(a); ib = int'(b);
        sa = (ia > 127) ? ia - 256 : ia;
        sb = (ib > 127) ? ib - 256 : ib;
        ci = (op == C_ADC || op == C_SBC || op == C_CPC) ? int'(fi[0]) : 0;
        case (op)
            C_ADD, C_ADC: begin
                t = ia + ib + ci; r = t[7:0]; c = (t > 255);
                h = ((ia % 16) + (ib % 16) + ci) > 15;
                sv = sa + sb + ci; v = (sv > 127) || (sv < -128);
            end
            C_SUB, C_SBC, C_CP, C_CPC: begin
                t = ia - ib - ci; r = t[7:0]; c = (t < 0);
                h = (ia % 16) < ((ib % 16) + ci);
                sv = sa - sb - ci; v = (sv > 127) || (sv < -128);
                wr = !(op == C_CP || op == C_CPC);
            end
            C_AND: r = a & b;
            C_OR:  r = a | b;
            C_EOR: r = a ^ b;
            default: begin legal = 0; wr = 0; end
        endcase
        n = r[7];
        z = (r == 8'h00);
        if (op == C_SBC || op == C_CPC) z = z && fi[1];
        fo = legal ? {h, n ^ v, v, n, z, c} : fi;
    endfunction

    function automatic string op_req(input logic [5:0] op);
        case (op)
            C_ADD, C_ADC: return "R3";
            C_SUB, C_SBC: return "R4";
            C_CP, C_CPC:  return "R7";
            C_AND, C_OR, C_EOR: return "R9";
            default: return "R11";
        endcase
    endfunction

    // All tasks start and end just after a falling edge
    task automatic load(input int idx, input logic [7:0] val);
        ext_we = 1'b1; ext_waddr = 5'(idx); ext_wdata = val;
        @(posedge clk); @(negedge clk);
        ext_we = 1'b0;
        mreg[idx] = val;
    endtask

    task automatic run_op(input logic [5:0] op, input int d, input int s, input bit do_check);
        logic [7:0] r; logic [5:0] fo; bit wr, legal;
        logic [4:0] dd, ss;
        string req;
        dd = 5'(d); ss = 5'(s);
        insn_word = {op, ss[4], dd[4], dd[3:0], ss[3:0]};
        insn_valid = 1'b1;
        model_exec(op, mreg[d], mreg[s], mflags, r, fo, wr, legal);
        @(posedge clk); @(negedge clk);
        insn_valid = 1'b0;
        if (wr) mreg[d] = r;
        mflags = fo;
        if (do_check) begin
            req = op_req(op);
            ext_raddr = dd; #1;
            check(req, "dest register", int'(ext_rdata), int'(mreg[d]));
            if (op == C_SBC || op == C_CPC) req = "R8";
            else if (op != C_AND && op != C_OR && op != C_EOR) req = "R5";
            check(req, "status", int'(status), int'(mflags));
        end
    endtask

    // Presets: 0 -> C0 Z1 H0, 1 -> C1 Z1 H1, 2 -> C0 Z0 H0, 3 -> C1 Z0 H1
    task automatic preset(input int p);
        case (p)
            0: begin load(30, 8'h00); load(31, 8'h00); end
            1: begin load(30, 8'hFF); load(31, 8'h01); end
            2: begin load(30, 8'h01); load(31, 8'h00); end
            default: begin load(30, 8'hFF); load(31, 8'h02); end
        endcase
        run_op(C_ADD, 30, 31, 1'b0);
    endtask

    task automatic read_check(input string req, input string what, input int idx, input int exp);
        ext_raddr = 5'(idx); #1;
        check(req, what, int'(ext_rdata), exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [5:0] ops [9];
        ops = '{C_ADD, C_ADC, C_SUB, C_SBC, C_CP, C_CPC, C_AND, C_OR, C_EOR};
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        mflags = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1", "status after reset", int'(status), 0);
        read_check("R1", "reg0 after reset", 0, 0);
        read_check("R1", "reg31 after reset", 31, 0);

        // R2: field positions, destination {b8,b7:4}, source {b9,b3:0}
        load(17, 8'h05); load(3, 8'h09);
        run_op(C_ADD, 17, 3, 1'b0);
        read_check("R2", "dest r17 sum", 17, 8'h0E);
        read_check("R2", "source r3 untouched", 3, 8'h09);
        load(2, 8'h30); load(18, 8'h04);
        run_op(C_OR, 2, 18, 1'b0);
        read_check("R2", "dest r2 or", 2, 8'h34);
        read_check("R2", "source r18 untouched", 18, 8'h04);

        // R3: sum of exactly 256 gives Z and C
        load(4, 8'h80); load(5, 8'h80);
        run_op(C_ADD, 4, 5, 1'b0);
        read_check("R3", "256 sum result", 4, 0);
        check("R3", "256 sum C,Z", int'(status[1:0]), 2'b11);

        // R6: rotate left through carry
        preset(1);
        load(20, 8'h81);
        run_op(C_ADC, 20, 20, 1'b0);
        read_check("R6", "rotate with C=1", 20, 8'h03);
        check("R6", "rotate C out", int'(status[0]), 1);
        preset(0);
        load(20, 8'h40);
        run_op(C_ADC, 20, 20, 1'b0);
        read_check("R6", "rotate with C=0", 20, 8'h80);
        check("R6", "rotate C out zero", int'(status[0]), 0);

        // R10: self exclusive-OR clears; self AND
        load(9, 8'h5A);
        run_op(C_EOR, 9, 9, 1'b0);
        read_check("R10", "self xor cleared", 9, 0);
        check("R10", "self xor Z", int'(status[1]), 1);
        load(9, 8'h10);
        run_op(C_AND, 9, 9, 1'b0);
        read_check("R10", "self and keeps value", 9, 8'h10);
        check("R10", "self and nonzero Z", int'(status[1]), 0);
        load(9, 8'h00);
        run_op(C_AND, 9, 9, 1'b0);
        check("R10", "self and zero Z", int'(status[1]), 1);

        // R8: chained compare keeps prior Z on equal operands
        preset(2);
        load(1, 8'h07); load(2, 8'h07);
        run_op(C_CPC, 1, 2, 1'b0);
        check("R8", "equal cpc with Z=0", int'(status[1]), 0);
        preset(0);
        run_op(C_CPC, 1, 2, 1'b0);
        check("R8", "equal cpc with Z=1", int'(status[1]), 1);
        read_check("R7", "cpc no writeback", 1, 8'h07);

        // R11: unknown operation code
        preset(3);
        load(5, 8'h66); load(6, 8'h11);
        run_op(6'b111111, 5, 6, 1'b0);
        read_check("R11", "unknown code reg", 5, 8'h66);
        check("R11", "unknown code status", int'(status), int'(mflags));

        // R13: idle cycle with a live-looking word
        insn_word = {C_EOR, 1'b0, 1'b0, 4'd5, 4'd6};
        @(posedge clk); @(negedge clk);
        read_check("R13", "idle reg", 5, 8'h66);
        check("R13", "idle status", int'(status), int'(mflags));

        // R12: collision and parallel writes
        load(6, 8'h01); load(7, 8'h02);
        ext_we = 1'b1; ext_waddr = 5'd6; ext_wdata = 8'hEE;
        run_op(C_ADD, 6, 7, 1'b0);
        ext_we = 1'b0;
        read_check("R12", "collision writeback wins", 6, 8'h03);
        ext_we = 1'b1; ext_waddr = 5'd8; ext_wdata = 8'h44;
        run_op(C_ADD, 6, 7, 1'b0);
        ext_we = 1'b0;
        mreg[8] = 8'h44;
        read_check("R12", "parallel writeback", 6, 8'h05);
        read_check("R12", "parallel ext write", 8, 8'h44);

        // Sweep: every operation, operand grid, four flag presets
        for (int oi = 0; oi < 9; oi++) begin
            for (int ka = 0; ka < 12; ka++) begin
                for (int kb = 0; kb < 12; kb++) begin
                    for (int p = 0; p < 4; p++) begin
                        int d, s;
                        d = (ka * 7 + kb * 3 + p) % 30;
                        s = (d + 1 + ((ka + kb + oi) % 28)) % 30;
                        preset(p);
                        load(d, sweep_val(ka));
                        load(s, sweep_val(kb));
                        run_op(ops[oi], d, s, 1'b1);
                    end
                end
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule